// File: doc/BRIEF.md
# TLB-Backed Virtual-to-Physical Address Translator

The unit turns a 14-bit virtual address into a 12-bit physical address for a system with 64-byte pages. The low six bits of the address select a byte inside the page and pass through untouched. The eight-bit virtual page number is looked up in a 16-entry translation buffer, organised as four sets of four ways.

When the buffer holds the page, the six-bit physical page number comes straight from it and no memory access is made. When it does not, the unit walks the page table itself. It adds twice the page number to a table base address, issues a single read on a request/response port and examines the returned entry. A valid entry is installed in the buffer and completes the translation. An entry whose valid bit is clear ends the request with a page fault.

Only one translation is in flight at a time. A ready output handshakes new requests, and a one-cycle done strobe presents the result. A flush input empties the buffer in one cycle.

Top module: `addr_xlate_unit`

## Requirements
- R1: A successful translation returns pa_o = {physical page number, va[5:0]}; the six offset bits are copied unchanged.
- R2: The buffer set is chosen by page-number bits [1:0] and the stored tag is page-number bits [7:2]. A page whose tag is present in a different set misses.
- R3: A hit raises done_o in the second cycle after the accepting edge, with hit_o=1 and fault_o=0, and issues no memory request.
- R4: A miss issues exactly one one-cycle mem_req_o, with mem_addr_o = ptbase_i + 2*page number (ptbase_i is sampled at acceptance). The response entry carries the valid flag in bit 6 and the physical page number in bits [5:0].
- R5: A response with bit 6 clear gives done_o with fault_o=1, hit_o=0 and pa_o=0. Nothing is installed, so repeating the same address walks the table again.
- R6: A valid walked entry is installed, so the next access to that page hits.
- R7: A fill goes to the lowest-numbered empty way of its set. When all four ways are full, it goes to the way named by that set's rotating pointer, and the pointer then advances by one.
- R8: ready_o is low from the accepting edge until done_o has been shown. A req_valid_i raised while ready_o is low is ignored.
- R9: One cycle of flush_i empties every buffer entry and returns every rotating pointer to way 0.
- R10: After reset, ready_o=1, done_o=0, mem_req_o=0 and the buffer is empty.
- R11: done_o is a one-cycle pulse, and pa_o, hit_o and fault_o are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the translation buffer |
| req_valid_i | input | 1 | Translation request |
| req_va_i | input | 14 | Virtual address |
| ptbase_i | input | 12 | Page table base address |
| ready_o | output | 1 | Unit can accept a request |
| mem_req_o | output | 1 | Page table read strobe |
| mem_addr_o | output | 12 | Page table entry address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 7 | Entry: bit 6 valid, [5:0] page number |
| done_o | output | 1 | Result strobe |
| pa_o | output | 12 | Physical address |
| hit_o | output | 1 | Result came from the buffer |
| fault_o | output | 1 | Page fault |

## Verification
The hardest state to reach is the replacement choice once a set is full. From the ports it can only be seen as which earlier page later misses. The stimulus flushes the buffer, then makes five walks to pages that share set 0: the fifth must displace way 0. It then probes the survivors and the victim in an order that only matches when the pointer advances past way 1 and then way 2. The fault path is revisited on the same address, and a second walk on that repeat shows that the faulting entry was not installed.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_WAIT,
    ST_DONE
  } xl_state_e;
endpackage

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             use_ptr_o
);
  always_comb begin
    way_o     = ptr_i;
    use_ptr_o = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) begin
        way_o     = WAY_W'(w);
        use_ptr_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PPN_W-1:0] fill_ppn_i
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] vic_way [SETS];
  logic [SETS-1:0]  vic_ptr;
  logic [WAYS-1:0]  match;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    victim_pick #(.WAYS(WAYS)) u_vic (
      .vld_i    (vld_q[s]),
      .ptr_i    (ptr_q[s]),
      .way_o    (vic_way[s]),
      .use_ptr_o(vic_ptr[s])
    );
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
  end

  always_comb begin
    ppn_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) ppn_o = ppn_o | ppn_q[lk_set_i][w];
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          ppn_q[s][w] <= '0;
        end
      end
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else if (fill_i) begin
      tag_q[fill_set_i][vic_way[fill_set_i]] <= fill_tag_i;
      ppn_q[fill_set_i][vic_way[fill_set_i]] <= fill_ppn_i;
      vld_q[fill_set_i][vic_way[fill_set_i]] <= 1'b1;
      if (vic_ptr[fill_set_i]) ptr_q[fill_set_i] <= ptr_q[fill_set_i] + 1'b1;
    end
  end
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int PA_W      = 12,
  parameter int OFF_W     = 6,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int PTE_SZ_LG = 1,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - SET_W,
  localparam int PTE_W = PPN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [PA_W-1:0]  ptbase_i,
  output logic             ready_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             done_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             hit_o,
  output logic             fault_o
);
  xl_state_e        state_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  ptb_q;
  logic [PA_W-1:0]  pa_q;
  logic             hit_q, flt_q;
  logic [VPN_W-1:0] vpn;
  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;
  logic             pte_vld, fill;

  assign vpn     = va_q[VA_W-1:OFF_W];
  assign pte_vld = mem_rsp_data_i[PTE_W-1];
  assign fill    = (state_q == ST_WAIT) && mem_rsp_valid_i && pte_vld;

  tlb_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)
  ) u_tlb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lk_set_i  (vpn[SET_W-1:0]),
    .lk_tag_i  (vpn[VPN_W-1:SET_W]),
    .hit_o     (tlb_hit),
    .ppn_o     (tlb_ppn),
    .fill_i    (fill),
    .fill_set_i(vpn[SET_W-1:0]),
    .fill_tag_i(vpn[VPN_W-1:SET_W]),
    .fill_ppn_i(mem_rsp_data_i[PPN_W-1:0])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      ptb_q   <= '0;
      pa_q    <= '0;
      hit_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          ptb_q   <= ptbase_i;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (tlb_hit) begin
          pa_q    <= {tlb_ppn, va_q[OFF_W-1:0]};
          hit_q   <= 1'b1;
          flt_q   <= 1'b0;
          state_q <= ST_DONE;
        end else begin
          state_q <= ST_MREQ;
        end
        ST_MREQ: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          hit_q   <= 1'b0;
          flt_q   <= !pte_vld;
          pa_q    <= pte_vld ? {mem_rsp_data_i[PPN_W-1:0], va_q[OFF_W-1:0]} : '0;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q == ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign mem_req_o  = (state_q == ST_MREQ);
  assign mem_addr_o = ptb_q + (PA_W'(vpn) << PTE_SZ_LG);
  assign pa_o       = pa_q;
  assign hit_o      = hit_q;
  assign fault_o    = flt_q;
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] req_va_i,
  input logic            ready_o,
  input logic            mem_req_o,
  input logic            done_o,
  input logic [PA_W-1:0] pa_o,
  input logic            hit_o,
  input logic            fault_o
);
  logic [OFF_W-1:0] off_cap;
  logic [1:0]       mreq_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cap  <= '0;
      mreq_cnt <= '0;
    end else if (req_valid_i && ready_o) begin
      off_cap  <= req_va_i[OFF_W-1:0];
      mreq_cnt <= '0;
    end else if (mem_req_o && mreq_cnt != 2'd3) begin
      mreq_cnt <= mreq_cnt + 2'd1;
    end
  end

  p_offset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> pa_o[OFF_W-1:0] == off_cap);
  p_hit_no_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> mreq_cnt == 2'd0);
  p_miss_one_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> mreq_cnt == 2'd1);
  p_req_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_fault_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (pa_o == '0 && !hit_o));
  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> !ready_o);
  p_not_ready_in_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind addr_xlate_unit xlate_checker #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_va_i   (req_va_i),
  .ready_o    (ready_o),
  .mem_req_o  (mem_req_o),
  .done_o     (done_o),
  .pa_o       (pa_o),
  .hit_o      (hit_o),
  .fault_o    (fault_o)
);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;
  localparam logic [11:0] PTB = 12'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_va = '0;
  logic        ready, mem_req, done, hit, fault;
  logic [11:0] mem_addr, pa;
  logic        rsp_valid = 1'b0;
  logic [6:0]  rsp_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int mreq_cnt = 0;
  logic [11:0] last_addr = '0;

  always #5 clk = ~clk;

  addr_xlate_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_va_i(req_va), .ptbase_i(PTB),
    .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .done_o(done), .pa_o(pa), .hit_o(hit), .fault_o(fault)
  );

  // page table model: bit 6 valid, [5:0] page number
  function automatic logic [6:0] pte_of(input logic [7:0] vpn);
    if (vpn == 8'h00) return {1'b1, 6'h28};
    if (vpn == 8'h0F) return {1'b1, 6'h0D};
    if (vpn == 8'h01 || vpn == 8'h06) return 7'h00;
    return {1'b1, vpn[5:0] ^ 6'h2A};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [11:0] off;
        mreq_cnt++;
        last_addr = mem_addr;
        off = mem_addr - PTB;
        repeat (2) @(negedge clk);
        rsp_data  = pte_of(off[8:1]);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [13:0] va, output logic r_hit, output logic r_flt,
                       output logic [11:0] r_pa, output int r_mreq, output int r_lat);
    int m0;
    @(negedge clk);
    m0 = mreq_cnt;
    req_valid = 1'b1;
    req_va    = va;
    @(negedge clk);
    req_valid = 1'b0;
    check(!ready, "R8 busy after accept", 32'(ready), 0);
    r_lat = 1;
    while (!done && r_lat < 40) begin
      @(negedge clk);
      r_lat++;
    end
    r_hit  = hit;
    r_flt  = fault;
    r_pa   = pa;
    r_mreq = mreq_cnt - m0;
    @(negedge clk);
    check(!done, "R11 done one cycle", 32'(done), 0);
  endtask

  function automatic logic [13:0] va_of(input logic [7:0] vpn);
    return {vpn, 6'h15};
  endfunction

  // expect a clean translation of vpn; want_hit selects hit or walk
  task automatic expect_ok(input logic [7:0] vpn, input bit want_hit, input string req);
    logic h, f; logic [11:0] p; int m, l;
    xlate(va_of(vpn), h, f, p, m, l);
    check(h == want_hit && !f, req, {h, f}, {want_hit, 1'b0});
    check(p == {pte_of(vpn)[5:0], 6'h15}, {req, " pa"}, p, {pte_of(vpn)[5:0], 6'h15});
    check(m == (want_hit ? 0 : 1), {req, " reads"}, m, want_hit ? 0 : 1);
    if (want_hit) check(l == 2, "R3 hit latency", l, 2);
  endtask

  task automatic t_reset();
    check(ready == 1'b1, "R10 ready", 32'(ready), 1);
    check(done == 1'b0 && mem_req == 1'b0, "R10 idle outputs", {done, mem_req}, 0);
  endtask

  task automatic t_examples();
    logic h, f; logic [11:0] p; int m, l;
    xlate(14'h0020, h, f, p, m, l);
    check(!h && !f && p == 12'hA20, "R1 walk of 0x0020", p, 12'hA20);
    check(m == 1, "R4 one read", m, 1);
    check(last_addr == PTB, "R4 entry address vpn 0", last_addr, PTB);
    xlate(14'h0020, h, f, p, m, l);
    check(h && p == 12'hA20 && m == 0, "R6 refill then hit", {h, p}, {1'b1, 12'hA20});
    check(l == 2, "R3 hit latency", l, 2);
    xlate(14'h03D4, h, f, p, m, l);
    check(last_addr == PTB + 12'h1E, "R4 entry address vpn 0F", last_addr, PTB + 12'h1E);
    check(!h && p == 12'h354, "R1 walk of 0x03D4", p, 12'h354);
    xlate(14'h03D4, h, f, p, m, l);
    check(h && p == 12'h354 && m == 0, "R3 hit of 0x03D4", {h, p}, {1'b1, 12'h354});
  endtask

  task automatic t_fault();
    logic h, f; logic [11:0] p; int m, l;
    xlate(14'h0055, h, f, p, m, l);
    check(f && !h && p == 12'h000, "R5 fault result", {f, h, p}, {2'b10, 12'h000});
    check(m == 1, "R5 fault one read", m, 1);
    xlate(14'h0055, h, f, p, m, l);
    check(f && m == 1, "R5 fault not installed", m, 1);
  endtask

  task automatic t_sets();
    // vpn 0E shares tag 3 with cached vpn 0F but sits in set 2
    expect_ok(8'h0E, 1'b0, "R2 other set misses");
    expect_ok(8'h0F, 1'b1, "R2 original set still hits");
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    expect_ok(8'h0F, 1'b0, "R9 flush empties");
    expect_ok(8'h00, 1'b0, "R9 flush empties vpn 0");
  endtask

  task automatic t_replace();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    expect_ok(8'h04, 1'b0, "R7 fill way0");
    expect_ok(8'h08, 1'b0, "R7 fill way1");
    expect_ok(8'h0C, 1'b0, "R7 fill way2");
    expect_ok(8'h10, 1'b0, "R7 fill way3");
    expect_ok(8'h14, 1'b0, "R7 evict way0");
    expect_ok(8'h08, 1'b1, "R7 way1 kept");
    expect_ok(8'h0C, 1'b1, "R7 way2 kept");
    expect_ok(8'h10, 1'b1, "R7 way3 kept");
    expect_ok(8'h14, 1'b1, "R7 new entry hits");
    expect_ok(8'h04, 1'b0, "R7 victim gone, evict way1");
    expect_ok(8'h08, 1'b0, "R7 pointer moved, evict way2");
    expect_ok(8'h04, 1'b1, "R7 refilled hits");
    expect_ok(8'h10, 1'b1, "R7 way3 untouched");
    expect_ok(8'h0C, 1'b0, "R7 way2 evicted");
  endtask

  task automatic t_busy();
    int m0, l;
    @(negedge clk);
    m0 = mreq_cnt;
    req_valid = 1'b1;
    req_va    = va_of(8'h30);
    @(negedge clk);
    req_va = va_of(8'h31);
    l = 1;
    while (!done && l < 40) begin
      check(!ready, "R8 ready low while busy", 32'(ready), 0);
      @(negedge clk);
      l++;
    end
    req_valid = 1'b0;
    check(pa == {pte_of(8'h30)[5:0], 6'h15}, "R8 first request served", pa, {pte_of(8'h30)[5:0], 6'h15});
    repeat (6) @(negedge clk);
    check(mreq_cnt - m0 == 1 && !done, "R8 busy request ignored", mreq_cnt - m0, 1);
    check(ready, "R8 ready again", 32'(ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_examples();
    t_fault();
    t_sets();
    t_flush();
    t_replace();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule